// File: doc/BRIEF.md
# Self-Programming Command Arming Controller

The block is a small control register that sits between a CPU and a flash controller. Software writes a five-bit command code into it. A legal code arms a four-cycle window. In that window one store-to-program-memory strobe from the CPU is taken. The block then does one of three things:

- stores the CPU's 16-bit register-pair value into a local page buffer;
- issues a single-cycle request to the memory side, for a lock-bit set or a read-while-write section re-enable;
- starts a long page erase or page write, and halts the CPU until the memory side reports done.

The command bits clear by themselves. They clear when the operation ends, or when the window runs out with no strobe. Reading the register returns the bits that are armed at that moment.

The memory is modelled as a request, busy and done handshake. The page buffer is a word-addressed RAM. Its read port is brought out for the flash side.

Top module: `spm_arm_ctrl`

## Requirements
- R1: After reset the command readback is 0, `halt_o` is 0 and `mem_req_o` is 0.
- R2: A command write is accepted only for the codes 5'b00001, 5'b00011, 5'b00101, 5'b01001 and 5'b10001. An accepted code reads back on `cmd_rdata_o` from the next cycle. Any other code leaves the readback unchanged.
- R3: After an accepted write, a strobe on `spm_i` is taken in any one of the next four clock cycles. If no strobe arrives in those four cycles, the readback returns to 0 at the end of the fourth cycle.
- R4: A strobe that arrives with no armed window, or after the window has expired, has no effect. It produces no `mem_req_o` and no buffer write.
- R5: Code 5'b00001 followed by a strobe writes `r_data_i` into buffer word `z_i[OFF_W:1]`, where OFF_W = log2(PAGE_WORDS). Bit `z_i[0]` is ignored. The readback clears in the same cycle, and no memory request is made.
- R6: Code 5'b00011 followed by a strobe raises `mem_req_o` for one cycle, starting the cycle after the strobe. With it come `mem_op_o` = 1 (erase) and `mem_page_o` = `z_i[Z_W-1:OFF_W+1]`. `r_data_i` is not used.
- R7: Code 5'b00101 followed by a strobe does the same as R6, with `mem_op_o` = 2 (write).
- R8: During an erase or a write, `halt_o` is 1 and the readback keeps its code, with bit 0 high. The cycle after `mem_done_i` is sampled high, both `halt_o` and the readback are 0.
- R9: Code 5'b01001 issues `mem_op_o` = 3 (lock-bit set) and code 5'b10001 issues `mem_op_o` = 4 (section re-enable). Each is a one-cycle request with the page address. There is no halt, and the readback clears in the same cycle.
- R10: A command write while an erase or a write is in progress is ignored.
- R11: If a command write and an accepted strobe fall in the same cycle, the strobe is carried out and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 5 | Command code written |
| cmd_rdata_o | output | 5 | Current command bits |
| spm_i | input | 1 | Store-to-program-memory strobe from the CPU |
| z_i | input | Z_W | Address pointer |
| r_data_i | input | DATA_W | Register-pair data word |
| halt_o | output | 1 | CPU halt, high during erase or write |
| mem_req_o | output | 1 | One-cycle request to the memory side |
| mem_op_o | output | 3 | Operation: 1 erase, 2 write, 3 lock set, 4 section re-enable |
| mem_page_o | output | Z_W-1-OFF_W | Page address of the request |
| mem_done_i | input | 1 | Completion pulse from the memory side |
| buf_raddr_i | input | OFF_W | Page buffer read word address |
| buf_rdata_o | output | DATA_W | Page buffer read data |

## Verification
The hardest case to reach is the last edge of the window: a strobe in the fourth cycle after the write must be taken, and one in the fifth must be lost. The directed part sweeps the idle gap between write and strobe across zero to four cycles. The random part draws gaps of up to five cycles, mixes in illegal codes, and presses command writes while an erase or write is busy. A strobe and a write in the same cycle are set up directly.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CMD_W = 5;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_WRITE = 3'd2,
    OP_LOCK  = 3'd3,
    OP_RWW   = 3'd4,
    OP_FILL  = 3'd5
  } spm_op_e;

  localparam logic [CMD_W-1:0] CODE_FILL  = 5'b00001;
  localparam logic [CMD_W-1:0] CODE_ERASE = 5'b00011;
  localparam logic [CMD_W-1:0] CODE_WRITE = 5'b00101;
  localparam logic [CMD_W-1:0] CODE_LOCK  = 5'b01001;
  localparam logic [CMD_W-1:0] CODE_RWW   = 5'b10001;
endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
  import spm_pkg::*;
(
  input  logic [CMD_W-1:0] code_i,
  output spm_op_e          op_o,
  output logic             legal_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (code_i)
      CODE_FILL:  op_o = OP_FILL;
      CODE_ERASE: op_o = OP_ERASE;
      CODE_WRITE: op_o = OP_WRITE;
      CODE_LOCK:  op_o = OP_LOCK;
      CODE_RWW:   op_o = OP_RWW;
      default: begin
        op_o    = OP_NONE;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/spm_window.sv
module spm_window #(
  parameter int WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic take_i,
  output logic open_o,
  output logic expire_o
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          open_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      open_q <= 1'b1;
      cnt_q  <= CW'(WIN - 1);
    end else if (take_i || expire_o) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open_o   = open_q;
  assign expire_o = open_q && (cnt_q == '0) && !take_i;
endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spm_arm_ctrl.sv
module spm_arm_ctrl
  import spm_pkg::*;
#(
  parameter int Z_W        = 16,
  parameter int PAGE_WORDS = 32,
  parameter int DATA_W     = 16,
  parameter int WIN        = 4,
  localparam int OFF_W     = $clog2(PAGE_WORDS),
  localparam int PG_W      = Z_W - 1 - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [4:0]        cmd_wdata_i,
  output logic [4:0]        cmd_rdata_o,
  input  logic              spm_i,
  input  logic [Z_W-1:0]    z_i,
  input  logic [DATA_W-1:0] r_data_i,
  output logic              halt_o,
  output logic              mem_req_o,
  output logic [2:0]        mem_op_o,
  output logic [PG_W-1:0]   mem_page_o,
  input  logic              mem_done_i,
  input  logic [OFF_W-1:0]  buf_raddr_i,
  output logic [DATA_W-1:0] buf_rdata_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             busy_q;
  logic             req_q;
  spm_op_e          op_q;
  logic [PG_W-1:0]  page_q;

  spm_op_e wr_op, cur_op;
  logic    wr_legal, cur_legal;
  logic    win_open, win_expire;
  logic    stb_ok, wr_ok, fill_we;
  logic    unused_z_lsb;

  assign unused_z_lsb = z_i[0];

  spm_cmd_decode u_dec_wr (.code_i(cmd_wdata_i), .op_o(wr_op),  .legal_o(wr_legal));
  spm_cmd_decode u_dec_q  (.code_i(cmd_q),       .op_o(cur_op), .legal_o(cur_legal));

  // strobe only counts inside an open window and outside a long operation
  assign stb_ok  = spm_i && win_open && !busy_q && cur_legal;
  assign wr_ok   = cmd_we_i && wr_legal && !busy_q && !stb_ok;
  assign fill_we = stb_ok && (cur_op == OP_FILL);

  spm_window #(.WIN(WIN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wr_ok),
    .take_i   (stb_ok),
    .open_o   (win_open),
    .expire_o (win_expire)
  );

  spm_page_buf #(.WORDS(PAGE_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .we_i    (fill_we),
    .waddr_i (z_i[OFF_W:1]),
    .wdata_i (r_data_i),
    .raddr_i (buf_raddr_i),
    .rdata_o (buf_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      op_q   <= OP_NONE;
      page_q <= '0;
    end else begin
      req_q <= 1'b0;
      if (stb_ok) begin
        unique case (cur_op)
          OP_ERASE, OP_WRITE: begin
            busy_q <= 1'b1;
            req_q  <= 1'b1;
            op_q   <= cur_op;
            page_q <= z_i[Z_W-1:OFF_W+1];
          end
          OP_LOCK, OP_RWW: begin
            req_q  <= 1'b1;
            op_q   <= cur_op;
            page_q <= z_i[Z_W-1:OFF_W+1];
            cmd_q  <= '0;
          end
          default: cmd_q <= '0;
        endcase
      end else if (busy_q) begin
        if (mem_done_i) begin
          busy_q <= 1'b0;
          cmd_q  <= '0;
        end
      end else if (wr_ok) begin
        cmd_q <= cmd_wdata_i;
      end else if (win_expire) begin
        cmd_q <= '0;
      end
    end
  end

  assign cmd_rdata_o = cmd_q;
  assign halt_o      = busy_q;
  assign mem_req_o   = req_q;
  assign mem_op_o    = op_q;
  assign mem_page_o  = page_q;
endmodule

// File: rtl/spm_arm_chk.sv
module spm_arm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] cmd_rdata_o,
  input logic       spm_i,
  input logic       halt_o,
  input logic       mem_req_o,
  input logic [2:0] mem_op_o,
  input logic       mem_done_i
);
  AST_LEGAL_CONTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdata_o inside {5'b00000, 5'b00001, 5'b00011, 5'b00101, 5'b01001, 5'b10001}); // R2

  AST_REQ_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(spm_i) && $past(cmd_rdata_o[0]) && !$past(halt_o)); // R4

  AST_HALT_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> cmd_rdata_o[0]); // R8

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && mem_done_i |=> !halt_o && (cmd_rdata_o == 5'b0)); // R8

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !mem_done_i |=> halt_o && $stable(cmd_rdata_o)); // R10

  AST_SINGLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R9

  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> mem_req_o && (mem_op_o == 3'd1 || mem_op_o == 3'd2)); // R6 R7
endmodule

bind spm_arm_ctrl spm_arm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_rdata_o (cmd_rdata_o),
  .spm_i       (spm_i),
  .halt_o      (halt_o),
  .mem_req_o   (mem_req_o),
  .mem_op_o    (mem_op_o),
  .mem_done_i  (mem_done_i)
);

// File: tb/sim_spm_arm_ctrl.sv
`timescale 1ns/1ps
module sim_spm_arm_ctrl;
  localparam int Z_W = 16, PW = 32, DW = 16, OFF_W = 5, PG_W = Z_W - 1 - OFF_W;

  logic clk = 0, rst_n = 0;
  logic we = 0, spm = 0, done = 0;
  logic [4:0] wdata = 0;
  logic [Z_W-1:0] z = 0;
  logic [DW-1:0] rd = 0;
  logic [OFF_W-1:0] raddr = 0;
  logic [4:0] rdata;
  logic halt, req;
  logic [2:0] op;
  logic [PG_W-1:0] page;
  logic [DW-1:0] bdata;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [DW-1:0] shadow [PW];
  bit shadow_v [PW];

  always #2 clk = ~clk;

  spm_arm_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(we), .cmd_wdata_i(wdata),
    .cmd_rdata_o(rdata), .spm_i(spm), .z_i(z), .r_data_i(rd),
    .halt_o(halt), .mem_req_o(req), .mem_op_o(op), .mem_page_o(page),
    .mem_done_i(done), .buf_raddr_i(raddr), .buf_rdata_o(bdata)
  );

  function automatic int exp_op(logic [4:0] c);
    case (c)
      5'b00001: return 5;
      5'b00011: return 1;
      5'b00101: return 2;
      5'b01001: return 3;
      5'b10001: return 4;
      default:  return 0;
    endcase
  endfunction
  function automatic logic [PG_W-1:0] exp_page(logic [Z_W-1:0] a);
    return a[Z_W-1:OFF_W+1];
  endfunction
  function automatic logic [OFF_W-1:0] exp_word(logic [Z_W-1:0] a);
    return a[OFF_W:1];
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_cmd(logic [4:0] c);
    we = 1; wdata = c; step(); we = 0;
  endtask

  task automatic strobe(logic [Z_W-1:0] a, logic [DW-1:0] d);
    z = a; rd = d; raddr = exp_word(a); spm = 1; step(); spm = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // one armed command, gap idle cycles, then a strobe; returns with the design idle
  task automatic run_cmd(logic [4:0] c, int gap, logic [Z_W-1:0] a, logic [DW-1:0] d, int lat);
    int o;
    bit armed;
    logic [OFF_W-1:0] w;
    o = exp_op(c);
    w = exp_word(a);
    write_cmd(c);
    check("R2 readback", rdata, (o != 0) ? c : 5'b0);
    for (int i = 0; i < gap; i++) begin
      step();
      if (i == 3) check("R3 expiry", rdata, 5'b0);
    end
    armed = (o != 0) && (gap <= 3);
    strobe(a, d);
    if (!armed) begin
      check("R4 no req", req, 0);
      check("R4 no halt", halt, 0);
      check("R4 buffer kept", shadow_v[w] ? bdata : 32'hx, shadow_v[w] ? shadow[w] : 32'hx);
    end else if (o == 5) begin
      shadow[w] = d; shadow_v[w] = 1;
      check("R5 fill data", bdata, d);
      check("R5 cleared", rdata, 0);
      check("R5 no req", req, 0);
    end else if (o == 3 || o == 4) begin
      check("R9 req", req, 1);
      check("R9 op", op, o);
      check("R9 page", page, exp_page(a));
      check("R9 no halt", halt, 0);
      check("R9 cleared", rdata, 0);
      step();
      check("R9 one cycle", req, 0);
    end else begin
      check(o == 1 ? "R6 req" : "R7 req", req, 1);
      check(o == 1 ? "R6 op" : "R7 op", op, o);
      check(o == 1 ? "R6 page" : "R7 page", page, exp_page(a));
      check("R8 halt", halt, 1);
      for (int i = 0; i < lat; i++) begin
        if (i == 0) begin
          we = 1; wdata = 5'b00001;
        end
        step();
        we = 0;
        check("R10 busy write ignored", rdata, c);
        check("R8 halt held", halt, 1);
      end
      done = 1; step(); done = 0;
      check("R8 halt released", halt, 0);
      check("R8 cleared", rdata, 0);
    end
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < PW; i++) shadow_v[i] = 0;
    void'($urandom(32'd1234));
    #5; check("R1 readback", rdata, 0); check("R1 halt", halt, 0); check("R1 req", req, 0);
    rst_n = 1; step();
    check("R1 after release", rdata, 0);

    // window edges
    for (int g = 0; g <= 4; g++) run_cmd(5'b00001, g, 16'h0041 + 16'(g*2), 16'hA000 + 16'(g), 0);
    run_cmd(5'b00011, 4, 16'h1234, 0, 1);
    // unarmed strobe
    strobe(16'h0003, 16'hDEAD);
    check("R4 unarmed fill", bdata, shadow[1]);
    check("R4 unarmed req", req, 0);
    // illegal codes
    write_cmd(5'b00111); check("R2 illegal 00111", rdata, 0);
    write_cmd(5'b10000); check("R2 illegal 10000", rdata, 0);
    // long operations and single-cycle ones
    run_cmd(5'b00011, 3, 16'hFFC0, 16'h5555, 3);
    run_cmd(5'b00101, 0, 16'h8041, 16'h1111, 0);
    run_cmd(5'b01001, 1, 16'h4080, 0, 0);
    run_cmd(5'b10001, 2, 16'h0140, 0, 0);
    // strobe and write same cycle
    write_cmd(5'b00001);
    we = 1; wdata = 5'b00011; strobe(16'h0010, 16'hBEEF); we = 0;
    shadow[8] = 16'hBEEF; shadow_v[8] = 1;
    check("R11 fill done", bdata, 16'hBEEF);
    check("R11 write dropped", rdata, 0);
    step();
    check("R11 no arm", rdata, 0);

    for (int n = 0; n < 300; n++) begin
      logic [4:0] c;
      int sel;
      sel = int'($urandom % 7);
      case (sel)
        0: c = 5'b00001; 1: c = 5'b00011; 2: c = 5'b00101;
        3: c = 5'b01001; 4: c = 5'b10001; 5: c = 5'b00001;
        default: c = 5'($urandom);
      endcase
      run_cmd(c, int'($urandom % 6), 16'($urandom), 16'($urandom), int'($urandom % 5));
    end
    finish_run();
  end
endmodule